// File: doc/BRIEF.md
# Byte-Addressed GPIO Port Register Bank

This block is the register core of a 16-pin general-purpose I/O port. A bus slave elsewhere in the chip turns serial traffic into single-cycle byte accesses (address, write data, write strobe, read strobe). The block keeps three writable 16-bit registers: pin direction, output level and input polarity. It also offers a read-only monitor view of the pins. It drives per-pin output-enable and output-value vectors to the pad ring, and it takes the raw pad inputs through a synchroniser.

Each 16-bit register takes two consecutive byte addresses, with bits 7:0 at the lower address. The monitor view returns the synchronised pin level XOR the polarity register, whatever the pin direction. When the serial link is shut down, the `link_down` input freezes all register state and outputs, so pins keep their configuration and levels.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset, direction, output level and polarity are all zero, so `pin_oe`, `pin_out` and `rd_data` read 0 and every pin is an input.
- R2: A write strobe to 0x14 loads direction bits 7:0 and a write to 0x15 loads bits 15:8. A direction bit of 1 makes the pin an output on `pin_oe` from the cycle after the write edge, and 0 makes it an input.
- R3: A write to 0x12 (bits 7:0) or 0x13 (bits 15:8) loads the output level register. `pin_out` shows it from the cycle after the write edge: 1 drives the pin high and 0 drives it low.
- R4: Reads at 0x12–0x17 return the byte last written to the same address. Output level is at 0x12/0x13, direction at 0x14/0x15 and polarity at 0x16/0x17, low byte at the even address.
- R5: Reads at 0x10 (bits 7:0) and 0x11 (bits 15:8) return the synchronised pin value XOR the polarity register. A pin change becomes visible to a read strobe sampled on the third rising edge after the change, and not before.
- R6: Writes to 0x10/0x11 and to any address outside 0x10–0x17 change no register and no output.
- R7: Reads at any address outside 0x10–0x17 return 0x00.
- R8: While `link_down` is 1, write and read strobes are ignored and `pin_oe`, `pin_out` and `rd_data` hold their values. Register contents are unchanged once the link returns.
- R9: `rd_data` updates only on the edge after an accepted read strobe (one cycle of read latency) and holds its value at all other times.
- R10: The monitor value does not depend on the pin direction: an output-configured pin still reports its synchronised input XOR polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_down | input | 1 | Serial link shut down: ignore strobes and hold all state |
| addr | input | 8 | Byte register address |
| wr_data | input | 8 | Byte write data |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 16 | Raw pad inputs, asynchronous |
| pin_oe | output | 16 | Per-pin output enable (direction register) |
| pin_out | output | 16 | Per-pin output value (level register) |

## Verification
The properties assume that `addr` and `wr_data` are valid whenever a strobe is sampled, and that `pin_in` may change on any cycle, since it only reaches the logic through the synchroniser. The stimulus drives every input on the falling clock edge, so each strobe lasts exactly one rising edge. It never mixes reads and writes in one cycle, and it changes `pin_in` only at points where the expected monitor value is recomputed. An exhaustive sweep of all 256 addresses, with writes and readback, covers decode and the ignored locations. A second sweep pairs pin patterns with polarity and direction patterns.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register slots in address order from the bank base; the order is decoded
  // by the bus slave, so it is fixed: monitor, level, direction, polarity.
  typedef enum logic [2:0] {
    SLOT_MON  = 3'd0,
    SLOT_LVL  = 3'd1,
    SLOT_DIR  = 3'd2,
    SLOT_POL  = 3'd3,
    SLOT_NONE = 3'd4
  } slot_e;

  localparam int unsigned SLOT_COUNT = 4;

  // Which register a byte address selects.
  function automatic slot_e addr_slot(input int unsigned a,
                                      input int unsigned base,
                                      input int unsigned lanes);
    int unsigned idx;
    if (a < base) return SLOT_NONE;
    idx = (a - base) / lanes;
    case (idx)
      0: return SLOT_MON;
      1: return SLOT_LVL;
      2: return SLOT_DIR;
      3: return SLOT_POL;
      default: return SLOT_NONE;
    endcase
  endfunction

  // Which byte lane of the selected register the address picks.
  function automatic int unsigned addr_lane(input int unsigned a,
                                            input int unsigned base,
                                            input int unsigned lanes);
    if (a < base) return 0;
    return (a - base) % lanes;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int PIN_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_fire,
  input  slot_e               slot,
  input  logic [((PIN_W/8)>1 ? $clog2(PIN_W/8) : 1)-1:0] lane,
  input  logic [7:0]          wr_data,
  output logic [PIN_W-1:0]    dir_q,
  output logic [PIN_W-1:0]    lvl_q,
  output logic [PIN_W-1:0]    pol_q
);
  localparam int LANES   = PIN_W / 8;
  localparam int LANE_IW = (LANES > 1) ? $clog2(LANES) : 1;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic       lane_hit;
    logic [7:0] dir_r, lvl_r, pol_r;

    assign lane_hit = wr_fire && (lane == LANE_IW'(l));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_r <= 8'h00;
        lvl_r <= 8'h00;
        pol_r <= 8'h00;
      end else if (lane_hit) begin
        case (slot)
          SLOT_DIR: dir_r <= wr_data;
          SLOT_LVL: lvl_r <= wr_data;
          SLOT_POL: pol_r <= wr_data;
          default:  ;
        endcase
      end
    end

    assign dir_q[l*8 +: 8] = dir_r;
    assign lvl_q[l*8 +: 8] = lvl_r;
    assign pol_q[l*8 +: 8] = pol_r;
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_bank_pkg::*;
#(
  parameter int PIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fire,
  input  slot_e            slot,
  input  logic [((PIN_W/8)>1 ? $clog2(PIN_W/8) : 1)-1:0] lane,
  input  logic [PIN_W-1:0] mon,
  input  logic [PIN_W-1:0] lvl,
  input  logic [PIN_W-1:0] dir,
  input  logic [PIN_W-1:0] pol,
  output logic [7:0]       rd_data
);
  logic [PIN_W-1:0] word;
  logic [7:0]       byte_sel;

  always_comb begin
    case (slot)
      SLOT_MON: word = mon;
      SLOT_LVL: word = lvl;
      SLOT_DIR: word = dir;
      SLOT_POL: word = pol;
      default:  word = '0;
    endcase
    byte_sel = 8'(word >> (32'(lane) * 8));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= 8'h00;
    end else if (rd_fire) begin
      rd_data <= byte_sel;
    end
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_bank_pkg::*;
#(
  parameter int          PIN_W       = 16,
  parameter int          ADDR_W      = 8,
  parameter int unsigned BASE_ADDR   = 32'h10,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_down,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_oe,
  output logic [PIN_W-1:0]  pin_out
);
  localparam int LANES   = PIN_W / 8;
  localparam int LANE_IW = (LANES > 1) ? $clog2(LANES) : 1;

  // Named internal events for the checker.
  logic               wr_fire, rd_fire;
  slot_e              acc_slot;
  logic [LANE_IW-1:0] acc_lane;
  logic [PIN_W-1:0]   sync_q, dir_q, lvl_q, pol_q, mon_word;

  assign wr_fire  = wr_en & ~link_down;
  assign rd_fire  = rd_en & ~link_down;
  assign acc_slot = addr_slot(32'(addr), BASE_ADDR, LANES);
  assign acc_lane = LANE_IW'(addr_lane(32'(addr), BASE_ADDR, LANES));

  gpio_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  gpio_port_regs #(.PIN_W(PIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .slot(acc_slot),
    .lane(acc_lane), .wr_data(wr_data),
    .dir_q(dir_q), .lvl_q(lvl_q), .pol_q(pol_q)
  );

  assign mon_word = sync_q ^ pol_q;

  gpio_read_mux #(.PIN_W(PIN_W)) u_rmux (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .slot(acc_slot),
    .lane(acc_lane), .mon(mon_word), .lvl(lvl_q), .dir(dir_q),
    .pol(pol_q), .rd_data(rd_data)
  );

  assign pin_oe  = dir_q;
  assign pin_out = lvl_q;
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk #(
  parameter int          PIN_W     = 16,
  parameter int          ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 32'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_down,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wr_data,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic [PIN_W-1:0]  pin_oe,
  input logic [PIN_W-1:0]  pin_out,
  input logic [7:0]        mon_lo
);
  localparam int unsigned LANES  = PIN_W / 8;
  localparam int unsigned LVL_LO = BASE_ADDR + LANES;
  localparam int unsigned DIR_LO = BASE_ADDR + 2 * LANES;
  localparam int unsigned TOP_A  = BASE_ADDR + 4 * LANES;

  int unsigned a;
  logic live_wr, live_rd, dir_hit, lvl_hit, mon_hit, mapped;

  assign a       = 32'(addr);
  assign live_wr = wr_en && !link_down;
  assign live_rd = rd_en && !link_down;
  assign dir_hit = (a >= DIR_LO) && (a < DIR_LO + LANES);
  assign lvl_hit = (a >= LVL_LO) && (a < LVL_LO + LANES);
  assign mon_hit = (a >= BASE_ADDR) && (a < LVL_LO);
  assign mapped  = (a >= BASE_ADDR) && (a < TOP_A);

  // R2
  dir_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_wr && a == DIR_LO |=> pin_oe[7:0] == $past(wr_data));

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(live_wr && dir_hit) |=> $stable(pin_oe));

  // R3
  lvl_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_wr && a == LVL_LO |=> pin_out[7:0] == $past(wr_data));

  // R3
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(live_wr && lvl_hit) |=> $stable(pin_out));

  // R5
  mon_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_rd && a == BASE_ADDR |=> rd_data == $past(mon_lo));

  // R6
  mon_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_wr && (mon_hit || !mapped) |=> $stable(pin_oe) && $stable(pin_out));

  // R7
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_rd && !mapped |=> rd_data == 8'h00);

  // R8
  link_down_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_down |=> $stable(pin_oe) && $stable(pin_out) && $stable(rd_data));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind gpio_port_bank gpio_port_bank_chk #(
  .PIN_W(PIN_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .link_down(link_down), .addr(addr),
  .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .pin_oe(pin_oe), .pin_out(pin_out), .mon_lo(mon_word[7:0])
);

// File: tb/sim_gpio_port_bank.sv
module sim_gpio_port_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_down = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wr_data = 8'h00;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [15:0] pin_in = 16'h0000;
  logic [15:0] pin_oe, pin_out;

  int total = 0;
  int fails = 0;
  bit done = 0;

  // Bench model of the writable registers and settled pins
  logic [15:0] m_dir = 0, m_lvl = 0, m_pol = 0, m_pins = 0;

  gpio_port_bank u0 (
    .clk(clk), .rst_n(rst_n), .link_down(link_down), .addr(addr),
    .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected read byte from the requirement map (R4, R5, R7)
  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    logic [15:0] w;
    if (a < 8'h10 || a > 8'h17) return 8'h00;
    case ((a - 8'h10) >> 1)
      0: w = m_pins ^ m_pol;
      1: w = m_lvl;
      2: w = m_dir;
      default: w = m_pol;
    endcase
    return a[0] ? w[15:8] : w[7:0];
  endfunction

  // Model update for an accepted write (R2, R3, R6)
  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h12: m_lvl[7:0]  = d;
      8'h13: m_lvl[15:8] = d;
      8'h14: m_dir[7:0]  = d;
      8'h15: m_dir[15:8] = d;
      8'h16: m_pol[7:0]  = d;
      8'h17: m_pol[15:8] = d;
      default: ;
    endcase
  endtask

  // Both tasks are entered and left at a falling edge.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic settle_pins(input logic [15:0] p);
    pin_in = p;
    m_pins = p;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, held;
    pin_in = 16'h3C81;
    m_pins = 16'h3C81;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk(pin_oe == 16'h0, "R1 pin_oe", 32'(pin_oe), 0);
    chk(pin_out == 16'h0, "R1 pin_out", 32'(pin_out), 0);
    chk(rd_data == 8'h0, "R1 rd_data", 32'(rd_data), 0);
    repeat (2) @(negedge clk);
    for (int a = 8'h12; a <= 8'h17; a++) begin
      rd(8'(a), r);
      chk(r == 8'h00, "R1 register reset", 32'(r), 0);
    end

    // R2 R3 R4 R6 R7: exhaustive address sweep with write then readback
    for (int a = 0; a < 256; a++) begin
      logic [7:0] d;
      d = 8'(a) ^ 8'h5C;
      wr(8'(a), d);
      model_wr(8'(a), d);
      chk(pin_oe == m_dir, "R2/R6 pin_oe after write", 32'(pin_oe), 32'(m_dir));
      chk(pin_out == m_lvl, "R3/R6 pin_out after write", 32'(pin_out), 32'(m_lvl));
      rd(8'(a), r);
      chk(r == exp_rd(8'(a)), "R4/R5/R7 readback", 32'(r), 32'(exp_rd(8'(a))));
    end

    // R5 R10: pin and polarity pattern sweep, direction varied
    for (int i = 0; i < 32; i++) begin
      logic [15:0] p, q, dv;
      p  = 16'(i * 16'h1357) ^ 16'(i << 9);
      q  = ~(16'(i * 16'h0F1D));
      dv = (i % 2 == 0) ? 16'hFFFF : 16'(i * 16'h0A0B);
      wr(8'h16, q[7:0]);  model_wr(8'h16, q[7:0]);
      wr(8'h17, q[15:8]); model_wr(8'h17, q[15:8]);
      wr(8'h14, dv[7:0]); model_wr(8'h14, dv[7:0]);
      wr(8'h15, dv[15:8]); model_wr(8'h15, dv[15:8]);
      settle_pins(p);
      rd(8'h10, r);
      chk(r == exp_rd(8'h10), "R5/R10 monitor low", 32'(r), 32'(exp_rd(8'h10)));
      rd(8'h11, r);
      chk(r == exp_rd(8'h11), "R5/R10 monitor high", 32'(r), 32'(exp_rd(8'h11)));
    end

    // R5: synchroniser latency, new value seen on the third edge only
    wr(8'h16, 8'h00); model_wr(8'h16, 8'h00);
    settle_pins(16'h00F0);
    pin_in = 16'h000F;
    rd(8'h10, r);
    chk(r == 8'hF0, "R5 latency edge1", 32'(r), 32'h F0);
    rd(8'h10, r);
    chk(r == 8'hF0, "R5 latency edge2", 32'(r), 32'h F0);
    rd(8'h10, r);
    chk(r == 8'h0F, "R5 latency edge3", 32'(r), 32'h0F);
    m_pins = 16'h000F;

    // R9: rd_data holds without a read strobe
    held = rd_data;
    pin_in = 16'h00A5;
    wr(8'h12, 8'h77); model_wr(8'h12, 8'h77);
    repeat (4) @(negedge clk);
    chk(rd_data == held, "R9 rd_data hold", 32'(rd_data), 32'(held));
    m_pins = 16'h00A5;

    // R8: link shut down freezes state and outputs
    begin
      logic [15:0] oe0, out0;
      oe0 = pin_oe; out0 = pin_out; held = rd_data;
      link_down = 1'b1;
      wr(8'h14, ~m_dir[7:0]);
      wr(8'h13, ~m_lvl[15:8]);
      wr(8'h17, ~m_pol[15:8]);
      rd(8'h14, r);
      chk(pin_oe == oe0, "R8 pin_oe held", 32'(pin_oe), 32'(oe0));
      chk(pin_out == out0, "R8 pin_out held", 32'(pin_out), 32'(out0));
      chk(rd_data == held, "R8 rd_data held", 32'(rd_data), 32'(held));
      link_down = 1'b0;
      rd(8'h14, r);
      chk(r == m_dir[7:0], "R8 direction kept", 32'(r), 32'(m_dir[7:0]));
      rd(8'h13, r);
      chk(r == m_lvl[15:8], "R8 level kept", 32'(r), 32'(m_lvl[15:8]));
      rd(8'h17, r);
      chk(r == m_pol[15:8], "R8 polarity kept", 32'(r), 32'(m_pol[15:8]));
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule